// File: doc/BRIEF.md
# Idle Controller with Wakeup Timer

This block puts a small 8-bit processor core into a low-power idle state and brings it back. A free-running up-counter advances on every instruction-cycle tick, whether the core runs or idles. Software enters idle by writing the idle bit of a control word. While idle, the core clock enable is withheld and only the counter keeps moving.

Idle ends on a synchronous reset, on a wake strobe from the external wakeup port, or when the counter's bit 12 changes value. That happens every 4096 ticks, about 4.1 ms at a 1 µs instruction cycle. Every change of that bit latches a sticky pending flag, and an enable bit gates the flag onto an interrupt request.

When idle ends, the block pulses exactly one of two resume strobes. One says the core must first service the timer interrupt. The other says it continues directly after the idle-entry instruction. The core clock enable then stays low for two more ticks so the clocks can resynchronize.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After reset, core_clk_en is 1, idle_flag, tmr_pend, tmr_irq and both resume strobes are 0, and tmr_val is 0.
- R2: tmr_val increases by one at each clock edge where cyc_tick is 1, in every state, and holds when cyc_tick is 0.
- R3: A control write (wr_en=1) with wr_data bit 0 set, made while running, sets idle_flag and clears core_clk_en at the next edge.
- R4: A wake_in strobe while idle clears idle_flag at the next edge and pulses resume_direct for one cycle, unless the timer ends idle with the interrupt enabled in that same cycle.
- R5: Each change of tmr_val bit 12, in either direction, sets tmr_pend at the same edge as the counter change.
- R6: tmr_pend stays set until a control write with wr_data bit 2 set. If that clearing write coincides with a new bit-12 change, the flag stays set.
- R7: Every control write loads the interrupt enable from wr_data bit 1, and tmr_irq equals tmr_pend AND the enable, updated at the same edge as both.
- R8: A bit-12 change while idle ends idle at that edge. It pulses resume_isr if the enable is set, and resume_direct otherwise, with tmr_pend set in both cases.
- R9: After idle ends, core_clk_en remains 0 for two further cyc_tick ticks and returns to 1 at the edge of the second.
- R10: A wakeup event (wake_in or a bit-12 change) in the same cycle as an idle-entry write prevents entry, and no resume strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Instruction-cycle tick |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 3 | Control word: bit 0 enter idle, bit 1 interrupt enable, bit 2 clear pending |
| wake_in | input | 1 | Wakeup strobe from the wakeup port |
| core_clk_en | output | 1 | Core clock enable, high only while running |
| idle_flag | output | 1 | Idle state flag |
| tmr_pend | output | 1 | Timer pending flag |
| tmr_irq | output | 1 | Timer interrupt request |
| resume_isr | output | 1 | One-cycle strobe: resume through the timer interrupt |
| resume_direct | output | 1 | One-cycle strobe: resume straight after idle entry |
| tmr_val | output | 16 | Idle timer count |

## Verification
Every cycle, the assertions check the counter's step and hold, that idle gates the core clock, and that a bit-12 change always leaves the pending flag set. They also check that the flag only drops on a clear write, that the interrupt never runs ahead of the flag, and that a wake strobe always ends idle. The scenarios are what show which resume path follows each wakeup, the exact tick on which the timer ends idle, and the two-tick resynchronization gap. They also show that a clear write coinciding with a toggle loses and that a wake coinciding with entry blocks it. A scoreboard queue holds the expected resume path for each idle episode and compares it against the strobes as they appear.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_SYNC = 2'd2
  } iwc_state_e;

  // control word fields
  localparam int unsigned CTRL_W = 3;
  localparam int unsigned F_IDLE = 0;
  localparam int unsigned F_TEN  = 1;
  localparam int unsigned F_CLR  = 2;
endpackage

// File: rtl/iwc_timer.sv
module iwc_timer #(
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned TOG_BIT = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [TMR_W-1:0] cnt,
  output logic             tog
);
  // tog is high in the cycle whose edge flips cnt[TOG_BIT]
  generate
    if (TOG_BIT == 0) begin : g_lsb
      assign tog = tick;
    end else begin : g_mid
      assign tog = tick & (&cnt[TOG_BIT-1:0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) cnt <= cnt + TMR_W'(1);
  end
endmodule

// File: rtl/iwc_flags.sv
module iwc_flags (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_ten,
  input  logic wr_clr,
  input  logic tog,
  output logic en_q,
  output logic pend_q,
  output logic irq_q
);
  logic pend_n, en_n;

  always_comb begin
    en_n   = wr_en ? wr_ten : en_q;
    pend_n = pend_q;
    if (wr_en && wr_clr) pend_n = 1'b0;
    if (tog) pend_n = 1'b1;           // a new toggle beats a clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
      irq_q  <= en_n & pend_n;
    end
  end
endmodule

// File: rtl/iwc_seq.sv
module iwc_seq
  import iwc_pkg::*;
#(
  parameter int unsigned RESYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       wr_idle,
  input  logic       wake_in,
  input  logic       tog,
  input  logic       en_q,
  output iwc_state_e state,
  output logic       res_isr,
  output logic       res_dir
);
  localparam int unsigned RS_W = (RESYNC > 1) ? $clog2(RESYNC) : 1;
  localparam int unsigned LAST = (RESYNC > 0) ? RESYNC - 1 : 0;

  logic [RS_W-1:0] rs_cnt;
  logic            wake_evt;

  assign wake_evt = wake_in | tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      rs_cnt  <= '0;
      res_isr <= 1'b0;
      res_dir <= 1'b0;
    end else begin
      res_isr <= 1'b0;
      res_dir <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (wr_en && wr_idle && !wake_evt) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (wake_evt) begin
            state   <= (RESYNC == 0) ? ST_RUN : ST_SYNC;
            rs_cnt  <= '0;
            res_isr <= tog & en_q;
            res_dir <= ~(tog & en_q);
          end
        end
        ST_SYNC: begin
          if (tick) begin
            if (rs_cnt == RS_W'(LAST)) state <= ST_RUN;
            else rs_cnt <= rs_cnt + RS_W'(1);
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import iwc_pkg::*;
#(
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned TOG_BIT = 12,
  parameter int unsigned RESYNC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_tick,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              wake_in,
  output logic              core_clk_en,
  output logic              idle_flag,
  output logic              tmr_pend,
  output logic              tmr_irq,
  output logic              resume_isr,
  output logic              resume_direct,
  output logic [TMR_W-1:0]  tmr_val
);
  iwc_state_e state;
  logic       tog;
  logic       en_q;

  iwc_timer #(.TMR_W(TMR_W), .TOG_BIT(TOG_BIT)) u_tmr (
    .clk(clk), .rst(rst), .tick(cyc_tick), .cnt(tmr_val), .tog(tog)
  );

  iwc_flags u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_ten(wr_data[F_TEN]), .wr_clr(wr_data[F_CLR]), .tog(tog),
    .en_q(en_q), .pend_q(tmr_pend), .irq_q(tmr_irq)
  );

  iwc_seq #(.RESYNC(RESYNC)) u_seq (
    .clk(clk), .rst(rst), .tick(cyc_tick), .wr_en(wr_en),
    .wr_idle(wr_data[F_IDLE]), .wake_in(wake_in), .tog(tog), .en_q(en_q),
    .state(state), .res_isr(resume_isr), .res_dir(resume_direct)
  );

  assign core_clk_en = (state == ST_RUN);
  assign idle_flag   = (state == ST_IDLE);
endmodule

// File: rtl/iwc_checker.sv
module iwc_checker
  import iwc_pkg::*;
#(
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned TOG_BIT = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_tick,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic              wake_in,
  input logic              core_clk_en,
  input logic              idle_flag,
  input logic              tmr_pend,
  input logic              tmr_irq,
  input logic              resume_isr,
  input logic              resume_direct,
  input logic [TMR_W-1:0]  tmr_val
);
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    cyc_tick |=> tmr_val == $past(tmr_val) + TMR_W'(1)); // R2
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cyc_tick |=> $stable(tmr_val)); // R2
  AST_IDLE_GATES_CLK: assert property (@(posedge clk) disable iff (rst)
    idle_flag |-> !core_clk_en); // R3
  AST_WAKE_EXITS: assert property (@(posedge clk) disable iff (rst)
    idle_flag && wake_in |=> !idle_flag && (resume_isr || resume_direct)); // R4
  AST_TOGGLE_PENDS: assert property (@(posedge clk) disable iff (rst)
    (tmr_val[TOG_BIT] != $past(tmr_val[TOG_BIT])) |-> tmr_pend); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    tmr_pend && !(wr_en && wr_data[F_CLR]) |=> tmr_pend); // R6
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    tmr_irq |-> tmr_pend); // R7
  AST_ONE_RESUME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resume_isr, resume_direct})); // R8
  AST_ISR_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
    resume_isr |-> tmr_pend && tmr_irq); // R8
  AST_RESYNC_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(idle_flag) |-> !core_clk_en); // R9
  AST_NO_ENTRY_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
    !idle_flag && wr_en && wr_data[F_IDLE] && wake_in |=> !idle_flag); // R10
endmodule

bind idle_wake_ctrl iwc_checker #(.TMR_W(TMR_W), .TOG_BIT(TOG_BIT)) u_chk (
  .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .wr_en(wr_en), .wr_data(wr_data),
  .wake_in(wake_in), .core_clk_en(core_clk_en), .idle_flag(idle_flag),
  .tmr_pend(tmr_pend), .tmr_irq(tmr_irq), .resume_isr(resume_isr),
  .resume_direct(resume_direct), .tmr_val(tmr_val)
);

// File: tb/test_idle_wake_ctrl.sv
module test_idle_wake_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_data = '0;
  logic        wake_in = 1'b0;
  logic        core_clk_en, idle_flag, tmr_pend, tmr_irq;
  logic        resume_isr, resume_direct;
  logic [15:0] tmr_val;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  bit exp_q[$];   // 1 = resume through interrupt, 0 = direct

  always #4 clk = ~clk;

  idle_wake_ctrl i_idle_wake_ctrl (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .wr_en(wr_en),
    .wr_data(wr_data), .wake_in(wake_in), .core_clk_en(core_clk_en),
    .idle_flag(idle_flag), .tmr_pend(tmr_pend), .tmr_irq(tmr_irq),
    .resume_isr(resume_isr), .resume_direct(resume_direct), .tmr_val(tmr_val)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle control write: bit0 idle, bit1 enable, bit2 clear
  task automatic ctrl_wr(logic [2:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_wake();
    for (int g = 0; g < 20000 && idle_flag; g++) step(1);
  endtask

  // scoreboard monitor: compares each resume strobe with the expected path
  always @(negedge clk) begin
    if (!rst && (resume_isr || resume_direct)) begin
      if (exp_q.size() == 0) chk("R8 unexpected resume", 1, 0);
      else chk("R8 resume path (1=isr)", {31'd0, resume_isr}, {31'd0, exp_q.pop_front()});
    end
  end

  function automatic void finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endfunction

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v0;
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 core_clk_en", core_clk_en, 1);
    chk("R1 idle_flag", idle_flag, 0);
    chk("R1 tmr_pend", tmr_pend, 0);
    chk("R1 tmr_irq", tmr_irq, 0);
    chk("R1 tmr_val", tmr_val, 0);

    // R2 hold then step
    cyc_tick = 1'b0; v0 = tmr_val;
    step(3);
    chk("R2 hold", tmr_val, v0);
    cyc_tick = 1'b1; v0 = tmr_val;
    step(5);
    chk("R2 count", tmr_val, 32'(v0 + 16'd5));

    // R3 enter idle, R2 counting continues while idle
    ctrl_wr(3'b001);
    chk("R3 idle_flag", idle_flag, 1);
    chk("R3 core_clk_en", core_clk_en, 0);
    v0 = tmr_val; step(4);
    chk("R2 count in idle", tmr_val, 32'(v0 + 16'd4));

    // R4 wake strobe, R9 resync gap
    exp_q.push_back(1'b0);
    wake_in = 1'b1; step(1); wake_in = 1'b0;
    chk("R4 idle cleared", idle_flag, 0);
    chk("R9 gap 0", core_clk_en, 0);
    step(1);
    chk("R9 gap 1", core_clk_en, 0);
    step(1);
    chk("R9 restored", core_clk_en, 1);

    // R10 wake coincides with entry
    wake_in = 1'b1; wr_en = 1'b1; wr_data = 3'b001;
    step(1);
    wake_in = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R10 no entry", idle_flag, 0);
    chk("R10 clk kept", core_clk_en, 1);

    // R5/R8 timer wake with enable clear -> direct
    chk("R5 no pend before toggle", tmr_pend, 0);
    exp_q.push_back(1'b0);
    ctrl_wr(3'b001);
    wait_wake();
    chk("R8 timer exit tick", tmr_val, 4096);
    chk("R5 pend on rise", tmr_pend, 1);
    chk("R8 no irq when disabled", tmr_irq, 0);

    // R7 enable raises irq, R6 plain write keeps pend
    step(3);
    ctrl_wr(3'b010);
    chk("R6 pend kept", tmr_pend, 1);
    chk("R7 irq on", tmr_irq, 1);
    ctrl_wr(3'b110);
    chk("R6 pend cleared", tmr_pend, 0);
    chk("R7 irq off", tmr_irq, 0);

    // R6 clear colliding with falling toggle: set wins (R5 falling edge)
    for (int g = 0; g < 8000 && tmr_val != 16'd8191; g++) step(1);
    ctrl_wr(3'b110);
    chk("R5 toggle fall value", tmr_val, 8192);
    chk("R6 set beats clear", tmr_pend, 1);
    chk("R7 irq with set", tmr_irq, 1);
    ctrl_wr(3'b110);
    chk("R6 cleared again", tmr_pend, 0);

    // R8 timer wake with enable set -> isr
    exp_q.push_back(1'b1);
    ctrl_wr(3'b011);
    chk("R3 idle with enable", idle_flag, 1);
    wait_wake();
    chk("R8 isr exit tick", tmr_val, 12288);
    chk("R8 pend set", tmr_pend, 1);
    chk("R8 irq set", tmr_irq, 1);
    step(2);
    chk("R9 restored after timer", core_clk_en, 1);

    step(2);
    chk("R8 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule